// File: doc/BRIEF.md
# Indexed attribute palette controller

This block is the register side of a pixel attribute stage. A host processor reaches sixteen palette entries and five control registers through one shared write port. An internal phase bit decides what each write on that port means. In the index phase the byte selects a register. In the data phase the byte is stored into the selected register. A read strobe on a separate port puts the phase bit back to the index phase. Software uses that strobe to resynchronise before each access sequence.

The index byte also carries a display-enable flag. While that flag is clear, or while the display timing reports blanking, the pixel output shows the overscan colour.

In normal operation each 4-bit pixel code passes through three steps, all combinational:
- it is masked by the plane-enable register;
- it selects a 6-bit palette entry;
- it is widened to an 8-bit colour index with bits taken from the colour-select register, in one of two arrangements chosen by the mode register.

Top module: `attr_palette_ctrl`

## Requirements
- R1: After reset all registers read as zero, the phase bit is in the index phase, and the display is disabled. The pixel output then equals the overscan value, which is zero.
- R2: A `rd_reset` strobe puts the phase bit into the index phase. When `rd_reset` and `wr_en` are high in the same cycle, that write is taken as an index byte.
- R3: A write in the index phase is followed by a write that is stored into the indexed register, and the write after that is an index again. With no write and no strobe, the phase holds.
- R4: Bit 5 of every index byte sets the display enable: 1 enables, 0 disables. `idx_rdata` returns the last index byte in full, including bits 7:6. Bits 4:0 of that byte form the register address.
- R5: `reg_rdata` returns the addressed register, zero-extended. The address map is:
  - 0x00–0x0F: palette entries, bits 5:0;
  - 0x10: mode, 8 bits;
  - 0x11: overscan, 8 bits;
  - 0x12: plane enable, bits 3:0;
  - 0x13: pan, bits 3:0;
  - 0x14: colour select, bits 3:0;
  - 0x15–0x1F: read as zero, and writes to them change nothing.
- R6: The pixel code is ANDed with plane enable [3:0] and then selects a palette entry. When mode bit 7 is 1, `pix_index` = {colour select [3:0], entry [3:0]}.
- R7: When mode bit 7 is 0, `pix_index` = {colour select [3:2], entry [5:0]}.
- R8: While the display is disabled or `pix_blank` is high, `pix_index` equals the overscan register.
- R9: `blink_sel` follows mode bit 3. A value of 1 means the top attribute bit blinks, and 0 means it selects background intensity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe on the shared index/data port |
| wr_data | input | 8 | Write byte |
| rd_reset | input | 1 | Read strobe on the phase-reset port |
| idx_rdata | output | 8 | Current index byte |
| reg_rdata | output | 8 | Contents of the addressed register |
| pix_code | input | 4 | Pixel code from the display pipeline |
| pix_blank | input | 1 | Blanking interval flag |
| pix_index | output | 8 | Colour index for the DAC |
| blink_sel | output | 1 | Blink versus intensity selection |

## Verification
The hardest situation to reach is a collision between `rd_reset` and a write, where the collision lands while the phase bit is in the data phase. Ordinary stimulus always places the strobe first, so the write never meets it in the data phase. The stimulus first writes a lone index to leave the block in the data phase. It then raises both strobes in one cycle. After that it checks three things: the byte became the new index, the following write landed in the register that byte selected, and the previously addressed entry kept its value.

// File: rtl/attr_pal_pkg.sv
package attr_pal_pkg;
  localparam int DW     = 8;
  localparam int CODE_W = 4;
  localparam int PAL_W  = 6;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 5;
  localparam int EN_BIT = 5;
  localparam int NUM_PAL = 1 << CODE_W;

  localparam logic [ADDR_W-1:0] A_MODE  = 5'h10;
  localparam logic [ADDR_W-1:0] A_OVSC  = 5'h11;
  localparam logic [ADDR_W-1:0] A_PLANE = 5'h12;
  localparam logic [ADDR_W-1:0] A_PAN   = 5'h13;
  localparam logic [ADDR_W-1:0] A_CSEL  = 5'h14;

  typedef enum logic {PH_INDEX = 1'b0, PH_DATA = 1'b1} phase_e;
endpackage

// File: rtl/attr_pal_seq.sv
module attr_pal_seq
  import attr_pal_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_reset,
  output logic [DW-1:0] idx_byte,
  output logic          disp_en,
  output logic          reg_we
);
  phase_e        phase_q, phase_d, eff_phase;
  logic [DW-1:0] idx_q, idx_d;
  logic          idx_load;

  always_comb begin
    eff_phase = rd_reset ? PH_INDEX : phase_q;
    idx_load  = wr_en && (eff_phase == PH_INDEX);
    reg_we    = wr_en && (eff_phase == PH_DATA);
    phase_d   = eff_phase;
    if (wr_en) phase_d = (eff_phase == PH_INDEX) ? PH_DATA : PH_INDEX;
    idx_d     = idx_load ? wr_data : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INDEX;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign idx_byte = idx_q;
  assign disp_en  = idx_q[EN_BIT];

  a_r2_strobe_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reset && !wr_en) |=> (phase_q == PH_INDEX));
  a_r2_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reset && wr_en) |=> (phase_q == PH_DATA && idx_q == $past(wr_data)));
  a_r3_data_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_reset && phase_q == PH_DATA) |=> (phase_q == PH_INDEX && $stable(idx_q)));
  a_r3_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_reset) |=> $stable(phase_q));
  a_r4_enable_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (rd_reset || phase_q == PH_INDEX)) |=> (disp_en == $past(wr_data[EN_BIT])));
endmodule

// File: rtl/attr_pal_regs.sv
module attr_pal_regs
  import attr_pal_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DW-1:0]                   wdata,
  output logic [NUM_PAL-1:0][PAL_W-1:0]   pal_o,
  output logic [DW-1:0]                   ovsc_o,
  output logic [NIB_W-1:0]                plane_o,
  output logic [NIB_W-1:0]                csel_o,
  output logic                            wide_sel_o,
  output logic                            blink_sel_o,
  output logic [DW-1:0]                   rdata
);
  logic [NUM_PAL-1:0][PAL_W-1:0] pal_q;
  logic [DW-1:0]    mode_q, mode_d, ovsc_q, ovsc_d;
  logic [NIB_W-1:0] plane_q, plane_d, pan_q, pan_d, csel_q, csel_d;
  logic             pal_hit;

  assign pal_hit = (addr < ADDR_W'(NUM_PAL));

  generate
    for (genvar g = 0; g < NUM_PAL; g++) begin : g_entry
      logic             hit;
      logic [PAL_W-1:0] nxt;
      assign hit = we && (addr == ADDR_W'(g));
      assign nxt = hit ? wdata[PAL_W-1:0] : pal_q[g];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pal_q[g] <= '0;
        else        pal_q[g] <= nxt;
      end
    end
  endgenerate

  always_comb begin
    mode_d  = mode_q;
    ovsc_d  = ovsc_q;
    plane_d = plane_q;
    pan_d   = pan_q;
    csel_d  = csel_q;
    if (we) begin
      case (addr)
        A_MODE:  mode_d  = wdata;
        A_OVSC:  ovsc_d  = wdata;
        A_PLANE: plane_d = wdata[NIB_W-1:0];
        A_PAN:   pan_d   = wdata[NIB_W-1:0];
        A_CSEL:  csel_d  = wdata[NIB_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      ovsc_q  <= '0;
      plane_q <= '0;
      pan_q   <= '0;
      csel_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      ovsc_q  <= ovsc_d;
      plane_q <= plane_d;
      pan_q   <= pan_d;
      csel_q  <= csel_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (pal_hit) begin
      rdata = DW'(pal_q[addr[CODE_W-1:0]]);
    end else begin
      case (addr)
        A_MODE:  rdata = mode_q;
        A_OVSC:  rdata = ovsc_q;
        A_PLANE: rdata = DW'(plane_q);
        A_PAN:   rdata = DW'(pan_q);
        A_CSEL:  rdata = DW'(csel_q);
        default: rdata = '0;
      endcase
    end
  end

  assign pal_o       = pal_q;
  assign ovsc_o      = ovsc_q;
  assign plane_o     = plane_q;
  assign csel_o      = csel_q;
  assign wide_sel_o  = mode_q[7];
  assign blink_sel_o = mode_q[3];

  a_r5_palette_store: assert property (@(posedge clk) disable iff (!rst_n)
    (we && pal_hit) |=> (pal_q[$past(addr[CODE_W-1:0])] == $past(wdata[PAL_W-1:0])));
  a_r5_unmapped_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr > A_CSEL) |=> ($stable(pal_q) && $stable(mode_q) && $stable(ovsc_q)
                               && $stable(plane_q) && $stable(pan_q) && $stable(csel_q)));
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(pal_q) && $stable(mode_q) && $stable(csel_q)));
endmodule

// File: rtl/attr_pal_lookup.sv
module attr_pal_lookup
  import attr_pal_pkg::*;
(
  input  logic [NUM_PAL-1:0][PAL_W-1:0] pal,
  input  logic [DW-1:0]                 ovsc,
  input  logic [NIB_W-1:0]              plane,
  input  logic [NIB_W-1:0]              csel,
  input  logic                          wide_sel,
  input  logic                          disp_en,
  input  logic [CODE_W-1:0]             pix_code,
  input  logic                          pix_blank,
  output logic [DW-1:0]                 pix_index
);
  logic [CODE_W-1:0] code_m;
  logic [PAL_W-1:0]  entry;
  logic [DW-1:0]     colour;

  always_comb begin
    code_m = pix_code & plane;
    entry  = pal[code_m];
    if (wide_sel) colour = {csel, entry[NIB_W-1:0]};
    else          colour = {csel[NIB_W-1:NIB_W-2], entry};
    pix_index = (!disp_en || pix_blank) ? ovsc : colour;
  end
endmodule

// File: rtl/attr_palette_ctrl.sv
module attr_palette_ctrl
  import attr_pal_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_reset,
  output logic [7:0]    idx_rdata,
  output logic [7:0]    reg_rdata,
  input  logic [3:0]    pix_code,
  input  logic          pix_blank,
  output logic [7:0]    pix_index,
  output logic          blink_sel
);
  logic [DW-1:0]                 idx_byte;
  logic                          disp_en, reg_we, wide_sel;
  logic [NUM_PAL-1:0][PAL_W-1:0] pal;
  logic [DW-1:0]                 ovsc;
  logic [NIB_W-1:0]              plane, csel;

  attr_pal_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_reset(rd_reset), .idx_byte(idx_byte), .disp_en(disp_en), .reg_we(reg_we)
  );

  attr_pal_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(idx_byte[ADDR_W-1:0]),
    .wdata(wr_data), .pal_o(pal), .ovsc_o(ovsc), .plane_o(plane), .csel_o(csel),
    .wide_sel_o(wide_sel), .blink_sel_o(blink_sel), .rdata(reg_rdata)
  );

  attr_pal_lookup u_lookup (
    .pal(pal), .ovsc(ovsc), .plane(plane), .csel(csel), .wide_sel(wide_sel),
    .disp_en(disp_en), .pix_code(pix_code), .pix_blank(pix_blank), .pix_index(pix_index)
  );

  assign idx_rdata = idx_byte;

  a_r8_overscan_shown: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_rdata[EN_BIT] || pix_blank) |-> (pix_index == ovsc));
  a_r6_wide_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_rdata[EN_BIT] && !pix_blank && wide_sel) |-> (pix_index[7:4] == csel));
  a_r7_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_rdata[EN_BIT] && !pix_blank && !wide_sel) |-> (pix_index[7:6] == csel[3:2]));
endmodule

// File: tb/attr_palette_ctrl_tb.sv
module attr_palette_ctrl_tb;
  logic       clk, rst_n, wr_en, rd_reset, pix_blank, blink_sel;
  logic [7:0] wr_data, idx_rdata, reg_rdata, pix_index;
  logic [3:0] pix_code;
  int tests = 0, fails = 0;

  attr_palette_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_reset(rd_reset),
    .idx_rdata(idx_rdata), .reg_rdata(reg_rdata), .pix_code(pix_code),
    .pix_blank(pix_blank), .pix_index(pix_index), .blink_sel(blink_sel)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {index byte, data byte, expected read-back}
  localparam logic [23:0] VEC [10] = '{
    24'h20_3F_3F, 24'h2F_FF_3F, 24'h25_2A_2A, 24'h30_88_88, 24'h31_5A_5A,
    24'h32_FF_0F, 24'h33_37_07, 24'h34_AB_0B, 24'h35_77_00, 24'h3F_12_00
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic flip;
    @(negedge clk); rd_reset = 1'b1;
    @(negedge clk); rd_reset = 1'b0;
  endtask

  task automatic setreg(input logic [7:0] i, input logic [7:0] v);
    flip; put(i); put(v);
  endtask

  function automatic logic [5:0] fpal(input int k);
    return 6'((k * 7 + 5) % 64);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; rd_reset = 1'b0;
    pix_code = '0; pix_blank = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 idx", idx_rdata, 8'h00);
    chk("R1 reg", reg_rdata, 8'h00);
    chk("R1 pix", pix_index, 8'h00);
    chk("R1 blink", {7'b0, blink_sel}, 8'h00);

    // R3 R4 R5 table walk
    for (int v = 0; v < 10; v++) begin
      flip; put(VEC[v][23:16]); put(VEC[v][15:8]);
      put(VEC[v][23:16]);
      chk("R4 idx readback", idx_rdata, VEC[v][23:16]);
      chk("R5 reg readback", reg_rdata, VEC[v][7:0]);
    end
    // R5 unmapped writes left overscan alone
    flip; put(8'h31);
    chk("R5 overscan kept", reg_rdata, 8'h5A);

    // R2 collision: enter data phase, then strobe and write together
    flip; put(8'h21);
    @(negedge clk); rd_reset = 1'b1; wr_en = 1'b1; wr_data = 8'h22;
    @(negedge clk); rd_reset = 1'b0; wr_en = 1'b0;
    chk("R2 write taken as index", idx_rdata, 8'h22);
    put(8'h15);
    put(8'h22);
    chk("R2 entry 2 stored", reg_rdata, 8'h15);
    flip; put(8'h21);
    chk("R2 entry 1 untouched", reg_rdata, 8'h00);
    // R3 no write, no strobe: phase holds, next write is data
    repeat (3) @(negedge clk);
    put(8'h09);
    put(8'hE1);
    chk("R3 phase held", reg_rdata, 8'h09);
    chk("R4 bits 7:6 kept", idx_rdata, 8'hE1);

    // pixel setup
    for (int k = 0; k < 16; k++) setreg(8'(32'h20 | k), {2'b00, fpal(k)});
    setreg(8'h34, 8'h0B);
    setreg(8'h32, 8'h0F);
    setreg(8'h30, 8'h80);
    for (int k = 0; k < 16; k += 5) begin
      @(negedge clk); pix_code = 4'(k); #1;
      chk("R6 wide lookup", pix_index, {4'hB, fpal(k)[3:0]});
    end
    setreg(8'h30, 8'h00);
    for (int k = 1; k < 16; k += 7) begin
      @(negedge clk); pix_code = 4'(k); #1;
      chk("R7 narrow lookup", pix_index, {2'b10, fpal(k)});
    end
    chk("R9 intensity", {7'b0, blink_sel}, 8'h00);
    setreg(8'h32, 8'h05);
    @(negedge clk); pix_code = 4'hF; #1;
    chk("R6 plane mask", pix_index, {2'b10, fpal(5)});
    @(negedge clk); pix_blank = 1'b1; #1;
    chk("R8 blank", pix_index, 8'h5A);
    @(negedge clk); pix_blank = 1'b0;
    flip; put(8'h10);
    @(negedge clk); #1;
    chk("R8 disabled", pix_index, 8'h5A);
    put(8'h08);
    chk("R9 blink", {7'b0, blink_sel}, 8'h01);
    flip; put(8'h20);
    @(negedge clk); #1;
    chk("R4 re-enabled", pix_index, {2'b10, fpal(5)});

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule